// File: doc/BRIEF.md
# Serial Control Port Protocol Auto-Detect

This block sits in front of a peripheral's serial control port. The port has three shared pins: a clock, a data line and an active-low select. The block watches those pins after power-on reset and works out from the host's first transaction whether the host speaks I2C or a 3-wire serial protocol. It then locks that choice until the next power-on reset. From then on it enables only the matching slave engine and feeds that engine clean copies of the pins.

Each pin passes through a synchronizer, and a one-cycle history of each synchronized value is kept for edge detection. An I2C start condition seen with the select pin high selects I2C. A clock falling edge seen with the select pin low selects 3-wire. After the lock, the block takes the data-line output enable from the chosen engine only. In I2C mode the data line is open-drain style. In 3-wire mode its direction follows the engine's read phase. The block also drives the pin pull-up enables. The clock and data pull-ups follow a configuration bit. The select-pin pull-up is on unless 3-wire mode is locked.

Top module: `ctlport_autodetect`

## Requirements
- R1: While `rst_n` is low, `mode_valid`, `mode_is_3w`, `lock_pulse`, `i2c_en`, `tw_en`, `sdata_oe` and `sdata_out` are all 0.
- R2: With no mode locked, suppose two consecutive synchronized samples show SDATA going 1→0 while the newer sample has SCLK=1 and SSN=1. Then I2C mode is locked: `mode_valid`=1 and `mode_is_3w`=0, visible after the third rising clock edge following the pin change.
- R3: With no mode locked, suppose two consecutive synchronized samples show SCLK going 1→0 while the newer sample has SSN=0. Then 3-wire mode is locked (`mode_valid`=1, `mode_is_3w`=1), with the same three-edge latency.
- R4: Once locked, the mode does not change for any later pin activity. Only `rst_n` low returns `mode_valid` to 0.
- R5: `lock_pulse` is 1 for exactly the one cycle in which `mode_valid` first becomes 1, and is 0 at all other times.
- R6: In I2C mode, `i2c_en`=1 and `tw_en`=0. `i2c_scl` and `i2c_sda` carry the synchronized SCLK and SDATA. SSN has no effect on any output. The 3-wire outputs idle at `tw_sclk`=0, `tw_ssn_n`=1 and `tw_sdata_in`=0.
- R7: In I2C mode, `sdata_oe` equals `i2c_sda_pull` and `sdata_out` is 0, so the line can only be pulled low or released.
- R8: In 3-wire mode, `tw_en`=1 and `i2c_en`=0. `tw_sclk`, `tw_ssn_n` and `tw_sdata_in` carry the synchronized SCLK, SSN and SDATA. The I2C outputs idle at `i2c_scl`=1 and `i2c_sda`=1.
- R9: In 3-wire mode, `sdata_oe` equals `tw_rd_phase` and `sdata_out` equals `tw_sdata_out`.
- R10: With no mode locked, both engine enables are 0 and `sdata_oe`=0 whatever the engine inputs do. The gated pin outputs sit at their idle values.
- R11: `pu_sclk_en` and `pu_sdata_en` equal `cfg_pullup_en` in every state. `pu_ssn_en` is 1 except when 3-wire mode is locked, where it is 0.
- R12: None of these patterns locks a mode: an SCLK falling edge with SSN high, an SDATA falling edge with SCLK low, SCLK and SDATA falling in the same sample with SSN high, or an SDATA falling edge with SSN low and SCLK steady high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sclk_pin | input | 1 | Raw serial clock pin |
| sdata_pin | input | 1 | Raw serial data pin (input side) |
| ssn_pin | input | 1 | Raw active-low select pin |
| cfg_pullup_en | input | 1 | Pull-up enable bit for the clock and data pins |
| i2c_sda_pull | input | 1 | I2C engine request to pull the data line low |
| tw_rd_phase | input | 1 | 3-wire engine read phase (block drives data) |
| tw_sdata_out | input | 1 | 3-wire engine output data bit |
| mode_valid | output | 1 | A mode has been locked |
| mode_is_3w | output | 1 | Locked mode is 3-wire (0 = I2C) |
| lock_pulse | output | 1 | One-cycle pulse when the mode locks |
| i2c_en | output | 1 | I2C engine enable |
| i2c_scl | output | 1 | Gated clock to the I2C engine |
| i2c_sda | output | 1 | Gated data to the I2C engine |
| tw_en | output | 1 | 3-wire engine enable |
| tw_sclk | output | 1 | Gated clock to the 3-wire engine |
| tw_ssn_n | output | 1 | Gated active-low select to the 3-wire engine |
| tw_sdata_in | output | 1 | Gated data to the 3-wire engine |
| sdata_oe | output | 1 | Data pin output enable |
| sdata_out | output | 1 | Data pin output value |
| pu_sclk_en | output | 1 | Clock pin pull-up enable |
| pu_sdata_en | output | 1 | Data pin pull-up enable |
| pu_ssn_en | output | 1 | Select pin pull-up enable |

## Verification
The hardest situations to reach from the ports are the near misses: pin movements that look like a start condition or a clock edge but must not lock a mode. The worst case is SCLK and SDATA falling in the same synchronized sample. The stimulus walks through each of these near misses before any legal selection, while the engine inputs are active, so that both no-lock and no-drive are observed. It then locks each mode in turn, with a power-on reset between them. After each lock it replays the other protocol's trigger to show that the choice holds.

// File: rtl/ctlport_pkg.sv
// Shared types for the serial control port auto-detect block.
// Assumes nothing beyond a single clock domain for all users.
package ctlport_pkg;

    // Locked protocol state; NONE until first qualifying bus activity.
    typedef enum logic [1:0] {
        CP_MODE_NONE = 2'd0,
        CP_MODE_I2C  = 2'd1,
        CP_MODE_3W   = 2'd2
    } cp_mode_e;

    // Number of shared control pins handled by the block.
    localparam int CP_NPINS = 3;

    // Bundle of the three control pins after synchronization.
    typedef struct packed {
        logic ssn;
        logic sdata;
        logic sclk;
    } cp_pins_t;

    // Idle level of every pin (pulled up when nobody drives).
    localparam cp_pins_t CP_PINS_IDLE = '{ssn: 1'b1, sdata: 1'b1, sclk: 1'b1};

endpackage

// File: rtl/ctlport_sync.sv
// Multi-stage synchronizer, one independent chain per bit.
// Assumes STAGES >= 2 and that each input bit is an asynchronous level;
// the chain resets to RESET_VAL so idle pins look idle straight after reset.
module ctlport_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[LAST];
    end

endmodule

// File: rtl/ctlport_detect.sv
// Edge history and protocol-trigger detection on the synchronized pins.
// Keeps one previous sample of each pin; a trigger is a combinational
// flag valid in the cycle the newer sample is present.
module ctlport_detect
    import ctlport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cp_pins_t cur,
    output logic     start_hit,
    output logic     fall_hit
);

    cp_pins_t prev;

    // Remember last cycle's synchronized pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= CP_PINS_IDLE;
        else        prev <= cur;
    end

    logic sda_fell;
    logic scl_fell;

    // Edge flags and the two qualifying trigger patterns.
    always_comb begin
        sda_fell  = prev.sdata & ~cur.sdata;
        scl_fell  = prev.sclk  & ~cur.sclk;
        start_hit = sda_fell & cur.sclk & cur.ssn;
        fall_hit  = scl_fell & ~cur.ssn;
    end

endmodule

// File: rtl/ctlport_lock.sv
// Mode lock register: captures the first trigger after reset and then
// ignores all later triggers. Start (I2C) takes priority if both flag.
// Emits a one-cycle pulse in the cycle the mode first becomes valid.
module ctlport_lock
    import ctlport_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_hit,
    input  logic     fall_hit,
    output cp_mode_e mode,
    output logic     lock_pulse
);

    // Latch the first qualifying trigger; only reset unlocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= CP_MODE_NONE;
            lock_pulse <= 1'b0;
        end else begin
            lock_pulse <= 1'b0;
            if (mode == CP_MODE_NONE) begin
                if (start_hit) begin
                    mode       <= CP_MODE_I2C;
                    lock_pulse <= 1'b1;
                end else if (fall_hit) begin
                    mode       <= CP_MODE_3W;
                    lock_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ctlport_route.sv
// Pin router: gates synchronized pins to the selected engine, picks the
// data-line driver and sets pull-up enables. Purely combinational;
// assumes mode comes from a register so outputs are glitch-free per cycle.
module ctlport_route
    import ctlport_pkg::*;
(
    input  cp_mode_e mode,
    input  cp_pins_t pins,
    input  logic     cfg_pullup_en,
    input  logic     i2c_sda_pull,
    input  logic     tw_rd_phase,
    input  logic     tw_sdata_out,
    output logic     i2c_en,
    output logic     i2c_scl,
    output logic     i2c_sda,
    output logic     tw_en,
    output logic     tw_sclk,
    output logic     tw_ssn_n,
    output logic     tw_sdata_in,
    output logic     sdata_oe,
    output logic     sdata_out,
    output logic     pu_sclk_en,
    output logic     pu_sdata_en,
    output logic     pu_ssn_en
);

    logic sel_i2c;
    logic sel_3w;

    // Decode the locked mode into per-engine selects.
    always_comb begin
        sel_i2c = (mode == CP_MODE_I2C);
        sel_3w  = (mode == CP_MODE_3W);
    end

    // Feed the I2C engine; idle-high lines when not selected.
    always_comb begin
        i2c_en  = sel_i2c;
        i2c_scl = sel_i2c ? pins.sclk  : 1'b1;
        i2c_sda = sel_i2c ? pins.sdata : 1'b1;
    end

    // Feed the 3-wire engine; deselected and quiet when not selected.
    always_comb begin
        tw_en       = sel_3w;
        tw_sclk     = sel_3w ? pins.sclk  : 1'b0;
        tw_ssn_n    = sel_3w ? pins.ssn   : 1'b1;
        tw_sdata_in = sel_3w ? pins.sdata : 1'b0;
    end

    // Data pin driver: open-drain for I2C, push-pull read data for 3-wire.
    always_comb begin
        sdata_oe  = 1'b0;
        sdata_out = 1'b0;
        if (sel_i2c) begin
            sdata_oe = i2c_sda_pull;
        end else if (sel_3w) begin
            sdata_oe  = tw_rd_phase;
            sdata_out = tw_sdata_out;
        end
    end

    // Pull-ups: clock/data from config, select pulled up unless 3-wire.
    always_comb begin
        pu_sclk_en  = cfg_pullup_en;
        pu_sdata_en = cfg_pullup_en;
        pu_ssn_en   = ~sel_3w;
    end

endmodule

// File: rtl/ctlport_autodetect.sv
// Top of the serial control port auto-detect block.
// Synchronizes the three raw pins, detects the first I2C start or
// 3-wire clock edge, locks the protocol until power-on reset and routes
// the pins to the matching engine. rst_n is the synchronous power-on reset.
module ctlport_autodetect
    import ctlport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic sdata_pin,
    input  logic ssn_pin,
    input  logic cfg_pullup_en,
    input  logic i2c_sda_pull,
    input  logic tw_rd_phase,
    input  logic tw_sdata_out,
    output logic mode_valid,
    output logic mode_is_3w,
    output logic lock_pulse,
    output logic i2c_en,
    output logic i2c_scl,
    output logic i2c_sda,
    output logic tw_en,
    output logic tw_sclk,
    output logic tw_ssn_n,
    output logic tw_sdata_in,
    output logic sdata_oe,
    output logic sdata_out,
    output logic pu_sclk_en,
    output logic pu_sdata_en,
    output logic pu_ssn_en
);

    cp_pins_t raw_pins;
    cp_pins_t sync_pins;
    logic     start_hit;
    logic     fall_hit;
    cp_mode_e mode;

    // Bundle raw pins in the package's field order.
    always_comb begin
        raw_pins.sclk  = sclk_pin;
        raw_pins.sdata = sdata_pin;
        raw_pins.ssn   = ssn_pin;
    end

    ctlport_sync #(
        .WIDTH     (CP_NPINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CP_PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (sync_pins)
    );

    ctlport_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (sync_pins),
        .start_hit (start_hit),
        .fall_hit  (fall_hit)
    );

    ctlport_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hit  (start_hit),
        .fall_hit   (fall_hit),
        .mode       (mode),
        .lock_pulse (lock_pulse)
    );

    ctlport_route u_route (
        .mode          (mode),
        .pins          (sync_pins),
        .cfg_pullup_en (cfg_pullup_en),
        .i2c_sda_pull  (i2c_sda_pull),
        .tw_rd_phase   (tw_rd_phase),
        .tw_sdata_out  (tw_sdata_out),
        .i2c_en        (i2c_en),
        .i2c_scl       (i2c_scl),
        .i2c_sda       (i2c_sda),
        .tw_en         (tw_en),
        .tw_sclk       (tw_sclk),
        .tw_ssn_n      (tw_ssn_n),
        .tw_sdata_in   (tw_sdata_in),
        .sdata_oe      (sdata_oe),
        .sdata_out     (sdata_out),
        .pu_sclk_en    (pu_sclk_en),
        .pu_sdata_en   (pu_sdata_en),
        .pu_ssn_en     (pu_ssn_en)
    );

    // Flatten the locked mode to status flags.
    always_comb begin
        mode_valid = (mode != CP_MODE_NONE);
        mode_is_3w = (mode == CP_MODE_3W);
    end

endmodule

// File: rtl/ctlport_autodetect_chk.sv
// Port-level property checker for ctlport_autodetect, bound to every
// instance. Observes only top-level ports.
module ctlport_autodetect_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_pullup_en,
    input logic mode_valid,
    input logic mode_is_3w,
    input logic lock_pulse,
    input logic i2c_en,
    input logic tw_en,
    input logic sdata_oe,
    input logic sdata_out,
    input logic pu_sclk_en,
    input logic pu_ssn_en
);

    // R4: a locked mode stays locked and unchanged.
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |=> (mode_valid && $stable(mode_is_3w)));

    // R5: the pulse marks the first cycle of a valid mode.
    a_r5_pulse_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_valid) |-> lock_pulse);

    // R5: no pulse except on the rising cycle of mode_valid.
    a_r5_pulse_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |-> $rose(mode_valid));

    // R10: nothing enabled or driven before a lock.
    a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (!sdata_oe && !i2c_en && !tw_en));

    // R6 R8: at most one engine enabled.
    a_r6_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i2c_en, tw_en}));

    // R7: in I2C mode the data line is never driven high.
    a_r7_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_en |-> !sdata_out);

    // R11: select pull-up follows the locked mode; clock pull-up follows config.
    a_r11_ssn_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && !mode_is_3w) |-> pu_ssn_en);

    a_r11_sclk_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        pu_sclk_en == cfg_pullup_en);

endmodule

bind ctlport_autodetect ctlport_autodetect_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pullup_en (cfg_pullup_en),
    .mode_valid    (mode_valid),
    .mode_is_3w    (mode_is_3w),
    .lock_pulse    (lock_pulse),
    .i2c_en        (i2c_en),
    .tw_en         (tw_en),
    .sdata_oe      (sdata_oe),
    .sdata_out     (sdata_out),
    .pu_sclk_en    (pu_sclk_en),
    .pu_ssn_en     (pu_ssn_en)
);

// File: tb/ctlport_autodetect_test.sv
// Bench: behavioural reference model with per-edge pin history queues,
// compared against every output at each falling clock edge.
module ctlport_autodetect_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic sclk_pin = 1'b1, sdata_pin = 1'b1, ssn_pin = 1'b1;
    logic cfg_pullup_en = 1'b1;
    logic i2c_sda_pull = 1'b0, tw_rd_phase = 1'b0, tw_sdata_out = 1'b0;
    logic mode_valid, mode_is_3w, lock_pulse, i2c_en, i2c_scl, i2c_sda;
    logic tw_en, tw_sclk, tw_ssn_n, tw_sdata_in, sdata_oe, sdata_out;
    logic pu_sclk_en, pu_sdata_en, pu_ssn_en;

    ctlport_autodetect uut (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .sdata_pin(sdata_pin),
        .ssn_pin(ssn_pin), .cfg_pullup_en(cfg_pullup_en),
        .i2c_sda_pull(i2c_sda_pull), .tw_rd_phase(tw_rd_phase),
        .tw_sdata_out(tw_sdata_out), .mode_valid(mode_valid),
        .mode_is_3w(mode_is_3w), .lock_pulse(lock_pulse), .i2c_en(i2c_en),
        .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .tw_en(tw_en),
        .tw_sclk(tw_sclk), .tw_ssn_n(tw_ssn_n), .tw_sdata_in(tw_sdata_in),
        .sdata_oe(sdata_oe), .sdata_out(sdata_out), .pu_sclk_en(pu_sclk_en),
        .pu_sdata_en(pu_sdata_en), .pu_ssn_en(pu_ssn_en)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state: 0 none, 1 I2C, 2 3-wire.
    int m_mode = 0;
    bit m_pulse = 1'b0;
    bit m_started = 1'b0;
    bit q_scl[$];
    bit q_sda[$];
    bit q_ssn[$];

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    // Model: pins seen by the design two samples back decide the lock.
    always @(posedge clk) begin
        bit c_scl, c_sda, c_ssn, p_sda, p_scl;
        if (!rst_n) begin
            m_mode = 0;
            m_pulse = 1'b0;
            q_scl = '{1, 1, 1};
            q_sda = '{1, 1, 1};
            q_ssn = '{1, 1, 1};
        end else begin
            c_scl = q_scl[$-1]; c_sda = q_sda[$-1]; c_ssn = q_ssn[$-1];
            p_scl = q_scl[$-2]; p_sda = q_sda[$-2];
            m_pulse = 1'b0;
            if (m_mode == 0) begin
                if (c_scl && p_sda && !c_sda && c_ssn) begin
                    m_mode = 1; m_pulse = 1'b1;
                end else if (!c_ssn && p_scl && !c_scl) begin
                    m_mode = 2; m_pulse = 1'b1;
                end
            end
            q_scl.push_back(sclk_pin);
            q_sda.push_back(sdata_pin);
            q_ssn.push_back(ssn_pin);
            while (q_scl.size() > 8) begin
                void'(q_scl.pop_front());
                void'(q_sda.pop_front());
                void'(q_ssn.pop_front());
            end
        end
        m_started = 1'b1;
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit s_scl, s_sda, s_ssn;
        if (m_started) begin
            s_scl = q_scl[$-1]; s_sda = q_sda[$-1]; s_ssn = q_ssn[$-1];
            chk("R2 R3 R4", "mode_valid", mode_valid, m_mode != 0);
            chk("R2 R3 R4", "mode_is_3w", mode_is_3w, m_mode == 2);
            chk("R5", "lock_pulse", lock_pulse, m_pulse);
            chk("R6 R10", "i2c_en", i2c_en, m_mode == 1);
            chk("R8 R10", "tw_en", tw_en, m_mode == 2);
            chk("R6", "i2c_scl", i2c_scl, (m_mode == 1) ? s_scl : 1'b1);
            chk("R6", "i2c_sda", i2c_sda, (m_mode == 1) ? s_sda : 1'b1);
            chk("R8", "tw_sclk", tw_sclk, (m_mode == 2) ? s_scl : 1'b0);
            chk("R8", "tw_ssn_n", tw_ssn_n, (m_mode == 2) ? s_ssn : 1'b1);
            chk("R8", "tw_sdata_in", tw_sdata_in, (m_mode == 2) ? s_sda : 1'b0);
            chk("R7 R9 R10", "sdata_oe", sdata_oe,
                (m_mode == 1) ? i2c_sda_pull : (m_mode == 2) ? tw_rd_phase : 1'b0);
            chk("R7 R9", "sdata_out", sdata_out, (m_mode == 2) ? tw_sdata_out : 1'b0);
            chk("R11", "pu_sclk_en", pu_sclk_en, cfg_pullup_en);
            chk("R11", "pu_sdata_en", pu_sdata_en, cfg_pullup_en);
            chk("R11", "pu_ssn_en", pu_ssn_en, m_mode != 2);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pins(input logic sc, input logic sd, input logic ss, input int n);
        sclk_pin = sc; sdata_pin = sd; ssn_pin = ss;
        tick(n);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #4000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1", "mode_valid", mode_valid, 1'b0);
        chk("R1", "lock_pulse", lock_pulse, 1'b0);
        chk("R1", "i2c_en", i2c_en, 1'b0);
        chk("R1", "tw_en", tw_en, 1'b0);
        chk("R1", "sdata_oe", sdata_oe, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // R10: engine requests while unlocked drive nothing
        i2c_sda_pull = 1'b1; tw_rd_phase = 1'b1; tw_sdata_out = 1'b1;
        tick(3);
        chk("R10", "sdata_oe", sdata_oe, 1'b0);
        chk("R10", "sdata_out", sdata_out, 1'b0);

        // R12: near misses
        pins(1'b0, 1'b1, 1'b1, 4);   // SCLK fall, SSN high
        pins(1'b0, 1'b0, 1'b1, 4);   // SDATA fall, SCLK low
        pins(1'b0, 1'b1, 1'b1, 2);
        pins(1'b1, 1'b1, 1'b1, 4);
        pins(1'b0, 1'b0, 1'b1, 4);   // both fall in one sample
        pins(1'b1, 1'b1, 1'b1, 4);
        pins(1'b1, 1'b1, 1'b0, 4);   // SSN low, SCLK steady high
        pins(1'b1, 1'b0, 1'b0, 4);   // SDATA fall
        pins(1'b1, 1'b1, 1'b0, 2);
        pins(1'b1, 1'b1, 1'b1, 4);
        chk("R12", "mode_valid", mode_valid, 1'b0);
        cfg_pullup_en = 1'b0; tick(2);
        chk("R11", "pu_sdata_en", pu_sdata_en, 1'b0);
        cfg_pullup_en = 1'b1;

        // R2: I2C start, then R4 replay of 3-wire trigger
        pins(1'b1, 1'b0, 1'b1, 4);
        chk("R2", "mode_valid", mode_valid, 1'b1);
        chk("R2", "mode_is_3w", mode_is_3w, 1'b0);
        for (int i = 0; i < 6; i++) begin
            pins(1'b0, i[0], i[1], 2);
            i2c_sda_pull = i[0];
            pins(1'b1, i[0], i[1], 2);
        end
        pins(1'b1, 1'b1, 1'b0, 3);
        pins(1'b0, 1'b1, 1'b0, 4);
        chk("R4", "mode_is_3w", mode_is_3w, 1'b0);
        chk("R6", "i2c_en", i2c_en, 1'b1);
        cfg_pullup_en = 1'b0; tick(2);
        chk("R11", "pu_ssn_en", pu_ssn_en, 1'b1);
        cfg_pullup_en = 1'b1;

        // R4: only reset unlocks
        pins(1'b1, 1'b1, 1'b1, 1);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(3);
        chk("R4", "mode_valid", mode_valid, 1'b0);

        // R3: 3-wire select, then R4 replay of an I2C start
        pins(1'b1, 1'b1, 1'b0, 4);
        pins(1'b0, 1'b1, 1'b0, 4);
        chk("R3", "mode_is_3w", mode_is_3w, 1'b1);
        for (int i = 0; i < 8; i++) begin
            tw_rd_phase = i[1];
            tw_sdata_out = i[0];
            pins(1'b1, i[2], 1'b0, 2);
            pins(1'b0, i[2], 1'b0, 2);
        end
        chk("R9", "sdata_out", sdata_out, tw_sdata_out);
        pins(1'b1, 1'b1, 1'b1, 4);
        pins(1'b1, 1'b0, 1'b1, 4);
        chk("R4", "mode_is_3w", mode_is_3w, 1'b1);
        chk("R11", "pu_ssn_en", pu_ssn_en, 1'b0);
        tick(2);
        finish_run();
    end

endmodule